// File: doc/BRIEF.md
# LCD-to-VGA Line Retimer

This block takes a parallel LCD pixel stream with a 25 MHz pixel clock and a 640x480, 60 Hz frame, and re-emits it with VGA timing. It needs no frame buffer. The LCD stream has only a front porch on each axis. VGA needs a front porch, a sync pulse and a back porch on both axes. The block closes that gap by running its own horizontal and vertical counters. An upstream sync detector supplies line and frame pulses, and the counters reload on those pulses. Each pixel is then held back in a short FIFO, so it comes out only once the VGA sync and back porch are over.

Only the most significant bit of each 3-bit colour channel is kept, so the output is one bit each for red, green and blue. The colour outputs are forced low outside the active window and whenever the sync detector reports that it has lost lock. If the FIFO ever runs dry during an active window, or overflows, a sticky error flag is set. The next frame pulse clears the flag and empties the FIFO, so the picture realigns within one frame.

Top module: `lcd_vga_retimer`

## Requirements
- R1: While `rst` is high, after a clock edge: `hsync_n` and `vsync_n` are 1, `rgb_out` is 0 and `err` is 0.
- R2: `in_rgb` holds red in bits 8:6, green in bits 5:3 and blue in bits 2:0. `rgb_out` is {in_rgb[8], in_rgb[5], in_rgb[2]}, with red in bit 2 and blue in bit 0. No other input bit affects `rgb_out`.
- R3: A pixel accepted in the same cycle as `line_start` appears on `rgb_out` exactly LAG+2 clock edges later. The following pixels of that line appear on consecutive cycles after it, for H_ACTIVE cycles in total.
- R4: The output line lasts H_TOTAL cycles. `hsync_n` is low for H_SYNC cycles, starting H_ACTIVE+H_FRONT cycles after the first active pixel of the line.
- R5: The output line that carries the input line accepted with `frame_start` is output line 0. `vsync_n` is low during output lines V_ACTIVE+V_FRONT through V_ACTIVE+V_FRONT+V_SYNC-1.
- R6: `rgb_out` is 0 outside the active window. This includes the horizontal porches and sync, and every output line from V_ACTIVE onward.
- R7: When `in_locked` is 0 at a clock edge, `rgb_out` is 0 after the next edge. Sync outputs are unaffected.
- R8: A read during the active window while the FIFO is empty sets `err`.
- R9: A pixel presented while the FIFO is full is discarded and sets `err`.
- R10: `err` stays set until a clock edge with `frame_start` high. That edge clears `err`, and the clear wins over a new error in the same cycle.
- R11: `frame_start` empties the FIFO, so the frame after an underflow or overflow comes out correctly aligned.
- R12: A `frame_start` arriving at any phase relative to the running counters re-locks the output timing to it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse with the first pixel of a frame |
| line_start | input | 1 | Pulse with the first pixel of each line |
| in_valid | input | 1 | Pixel data phase of the LCD stream |
| in_rgb | input | 9 | LCD pixel, 3 bits per channel, R,G,B from MSB |
| in_locked | input | 1 | Sync detector lock indication |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb_out | output | 3 | One bit per channel, R in bit 2 |
| err | output | 1 | Sticky FIFO underflow/overflow flag |

## Verification
The assertions check the following on every cycle:
- colour is dark whenever either sync is active, and after any cycle without lock;
- both counters land on their reload values right after the line and frame pulses;
- the error flag follows every empty read and every full write, and stays set until a frame pulse clears it;
- a full FIFO refuses a write.

Some behaviour only the bench's directed frames can show:
- the exact LAG+2 pixel latency and the choice of the channel MSBs;
- the position of the sync pulses within a whole frame;
- recovery in the frame after an underflow or overflow;
- re-locking to a frame pulse moved to a new phase.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  typedef logic [2:0] pix3_t;

  // Keep the top bit of each 3-bit channel: red 8:6, green 5:3, blue 2:0
  function automatic pix3_t channel_msbs(input logic [8:0] px);
    return {px[8], px[5], px[2]};
  endfunction
endpackage

// File: rtl/lvr_axis_counter.sv
module lvr_axis_counter #(
  parameter int TOTAL = 800,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  assign wrap = step && !load && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/lvr_delay_fifo.sv
module lvr_delay_fifo #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr, rd_ptr, occ;
  logic [AW-1:0]    waddr;
  logic             wr_ok, rd_ok;

  assign occ   = wr_ptr - rd_ptr;
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign empty = (wr_ptr == rd_ptr);
  assign wr_ok = wr && (flush || !full);
  assign rd_ok = rd && !empty && !flush;
  assign waddr = flush ? '0 : wr_ptr[AW-1:0];

  // Storage without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
    if (rd_ok) rdata <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= wr ? (AW+1)'(1) : '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !rd && !flush) |=> (occ == $past(occ)));
  assert_write_grows_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && !full && !rd && !flush) |=> (occ == $past(occ) + 1'b1));
endmodule

// File: rtl/lcd_vga_retimer.sv
module lcd_vga_retimer #(
  parameter int H_ACTIVE   = 640,
  parameter int H_FRONT    = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BACK     = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FRONT    = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 33,
  parameter int LAG        = 160,
  parameter int FIFO_DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       line_start,
  input  logic       in_valid,
  input  logic [8:0] in_rgb,
  input  logic       in_locked,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic [2:0] rgb_out,
  output logic       err
);
  import lvr_pkg::*;

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_ACT_END = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_BEGIN  = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] HS_END    = HW'(H_ACTIVE + H_FRONT + H_SYNC);
  localparam logic [VW-1:0] V_ACT_END = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_BEGIN  = VW'(V_ACTIVE + V_FRONT);
  localparam logic [VW-1:0] VS_END    = VW'(V_ACTIVE + V_FRONT + V_SYNC);
  localparam logic [HW-1:0] H_RELOAD  = HW'(H_TOTAL - LAG);
  localparam logic [VW-1:0] V_RELOAD  = VW'(V_TOTAL - 1);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_wrap, v_wrap_unused;
  logic          act, hs, vs;
  logic          act_q, hs_q, vs_q;
  logic          fifo_full, fifo_empty;
  pix3_t         fifo_q;

  // Counters: the line pulse puts active output LAG cycles later
  lvr_axis_counter #(.TOTAL(H_TOTAL), .W(HW)) i_hcnt (
    .clk(clk), .rst(rst), .step(1'b1), .load(line_start),
    .load_val(H_RELOAD), .cnt(h_cnt), .wrap(h_wrap));

  lvr_axis_counter #(.TOTAL(V_TOTAL), .W(VW)) i_vcnt (
    .clk(clk), .rst(rst), .step(h_wrap), .load(frame_start),
    .load_val(V_RELOAD), .cnt(v_cnt), .wrap(v_wrap_unused));

  assign act = (h_cnt < H_ACT_END) && (v_cnt < V_ACT_END);
  assign hs  = (h_cnt >= HS_BEGIN) && (h_cnt < HS_END);
  assign vs  = (v_cnt >= VS_BEGIN) && (v_cnt < VS_END);

  lvr_delay_fifo #(.WIDTH(3), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .flush(frame_start),
    .wr(in_valid), .wdata(channel_msbs(in_rgb)),
    .rd(act), .rdata(fifo_q), .full(fifo_full), .empty(fifo_empty));

  // Two-stage pipeline: stage 1 matches the FIFO read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      rgb_out <= '0;
      err     <= 1'b0;
    end else begin
      act_q   <= act;
      hs_q    <= hs;
      vs_q    <= vs;
      hsync_n <= !hs_q;
      vsync_n <= !vs_q;
      rgb_out <= (act_q && in_locked) ? fifo_q : '0;
      if (frame_start) err <= 1'b0;
      else if ((act && fifo_empty) || (in_valid && fifo_full)) err <= 1'b1;
    end
  end

  assert_blank_in_sync_R6: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n || !vsync_n) |-> (rgb_out == '0));
  assert_unlock_dark_R7: assert property (@(posedge clk) disable iff (rst)
    !in_locked |=> (rgb_out == '0));
  assert_h_reload_R3: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (h_cnt == H_RELOAD));
  assert_v_reload_R5: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (v_cnt == V_RELOAD));
  assert_underflow_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (act && fifo_empty && !frame_start) |=> err);
  assert_overflow_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fifo_full && !frame_start) |=> err);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (err && !frame_start) |=> err);
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !err);
endmodule

// File: tb/test_lcd_vga_retimer.sv
`timescale 1ns/1ps
module test_lcd_vga_retimer;
  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 4, VF = 1, VS = 1, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int LAG = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, frame_start, line_start, in_valid, in_locked;
  logic [8:0] in_rgb;
  logic       hsync_n, vsync_n, err;
  logic [2:0] rgb_out;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  lcd_vga_retimer #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .LAG(LAG), .FIFO_DEPTH(16)
  ) i_lcd_vga_retimer (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .in_valid(in_valid), .in_rgb(in_rgb), .in_locked(in_locked),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb_out(rgb_out), .err(err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] pix(input int l, input int x);
    return 9'((l * 53 + x * 29 + 7) ^ (x * x * 3));
  endfunction

  function automatic logic [2:0] msbs(input logic [8:0] p);
    return {p[8], p[5], p[2]};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      frame_start = 0; line_start = 0; in_valid = 0; in_rgb = 9'h1FF;
      @(posedge clk); @(negedge clk);
    end
  endtask

  // mode 0: clean frame, 1: line 1 missing, 2: data during vertical blank
  task automatic run_frame(input int mode, input bit lock, input string tag);
    for (int c = 0; c < VT * HT; c++) begin
      int l = c / HT;
      int x = c % HT;
      bit v;
      v = (l < VA) && (x < HA);
      if (mode == 1 && l == 1) v = 0;
      if (mode == 2 && l >= VA) v = 1;
      frame_start = (c == 0);
      line_start  = (x == 0);
      in_valid    = v;
      in_rgb      = v ? pix(l, x) : (9'h1FF ^ 9'(c));
      in_locked   = lock;
      @(posedge clk); @(negedge clk);
      if (c == 1) chk("R10 err cleared by frame_start", err, 0);
      if (c >= LAG + 2) begin
        int p  = c - LAG - 2;
        int pl = p / HT;
        int px = p % HT;
        chk("R4 hsync", hsync_n, !(px >= HA + HF && px < HA + HF + HS));
        chk("R5 vsync", vsync_n, !(pl >= VA + VF && pl < VA + VF + VS));
        if (pl < VA && px < HA) begin
          if (mode == 0 && lock) chk(tag, rgb_out, msbs(pix(pl, px)));
          else if (!lock) chk("R7 unlocked dark", rgb_out, 0);
        end else begin
          chk("R6 blank outside active", rgb_out, 0);
        end
      end
    end
    if (mode == 1) chk("R8 underflow sets err", err, 1);
    else if (mode == 2) chk("R9 overflow sets err", err, 1);
    else chk("R10 no err on clean frame", err, 0);
  endtask

  task automatic scen_reset();
    rst = 1; frame_start = 0; line_start = 0; in_valid = 0; in_rgb = 0; in_locked = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 hsync_n", hsync_n, 1);
    chk("R1 vsync_n", vsync_n, 1);
    chk("R1 rgb_out", rgb_out, 0);
    chk("R1 err", err, 0);
    rst = 0;
  endtask

  task automatic scen_normal();
    idle(37);
    run_frame(0, 1'b1, "R2 R3 pixel msbs and alignment");
    run_frame(0, 1'b1, "R2 R3 second frame");
  endtask

  task automatic scen_unlocked();
    run_frame(0, 1'b0, "R7");
    run_frame(0, 1'b1, "R3 after relock");
  endtask

  task automatic scen_underflow();
    run_frame(1, 1'b1, "R8");
    run_frame(0, 1'b1, "R11 realigned after underflow");
  endtask

  task automatic scen_overflow();
    run_frame(2, 1'b1, "R9");
    run_frame(0, 1'b1, "R11 realigned after overflow");
  endtask

  task automatic scen_shift();
    idle(5);
    run_frame(0, 1'b1, "R12 shifted frame_start");
    idle(11);
    run_frame(0, 1'b1, "R12 shifted again");
  endtask

  initial begin
    scen_reset();
    scen_normal();
    scen_unlocked();
    scen_underflow();
    scen_overflow();
    scen_shift();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule